// File: doc/BRIEF.md
# System Instruction Privilege Gate

This block sits beside an instruction decoder and rules on each decoded system instruction before it executes. It reads the current privilege level from the low bits of the code segment selector and an instruction-class code. In the same cycle it returns either a permit or a general-protection fault. Level 0 is the most privileged of four levels.

The block holds two pieces of architectural state. The first is the interrupt-enable flag, which a permitted disable or enable instruction changes. The second is the I/O privilege level, which only level-0 code may rewrite. The I/O privilege level relaxes the rule for the interrupt-flag and port-I/O instructions. Every other system instruction strictly needs level 0. A denied instruction leaves both pieces of state as they were.

Top module: `sysop_gate`

## Requirements
- R1: Synchronous active-high reset clears the interrupt flag to 0 and the I/O privilege level to 0, so right after reset a port-I/O request at level 3 faults.
- R2: The current level is `cs_sel_lo` (0..3). At level 0 every system class is permitted.
- R3: Interrupt disable (class 1) and interrupt enable (class 2) are permitted when the level is 0 or when the I/O privilege level is greater than or equal to the level. Otherwise they fault.
- R4: Port I/O (class 3) follows the same I/O-privilege rule as R3.
- R5: The following classes are permitted only at level 0 and fault at levels 1 to 3: descriptor-table load (4), control/debug register move (5), halt (6), model-specific register access (7), TLB entry invalidate (8).
- R6: A faulting request changes neither the interrupt flag nor the I/O privilege level.
- R7: A permitted class 1 clears the interrupt flag, and a permitted class 2 sets it. The new value appears on `int_flag` after the next rising clock edge.
- R8: An I/O privilege level write (class 9, value on `iopl_wdata`) is permitted only at level 0 and takes effect at the next edge. At levels 1 to 3 it faults and leaves the level unchanged.
- R9: Non-system classes (0 and 10 to 15) are always permitted and never fault.
- R10: `op_permit` and `op_gpfault` are combinational in the cycle of `op_valid`. Exactly one of them is high when `op_valid` is 1, and both are low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded instruction is presented this cycle |
| cs_sel_lo | input | 2 | Low bits of the code segment selector (current level) |
| op_class | input | 4 | Instruction-class code |
| iopl_wdata | input | 2 | New I/O privilege level for class 9 |
| op_permit | output | 1 | Instruction may execute |
| op_gpfault | output | 1 | General-protection fault |
| int_flag | output | 1 | Current interrupt-enable flag |

## Verification
An I/O privilege level write and a flag or port request can arrive in consecutive cycles. In that case the verdict on the second request must already use the newly written level, so the bench writes level 2 at level 0 and at once issues an interrupt disable at level 2 and an interrupt enable at level 3. A denied flag instruction can also arrive while the flag holds the opposite value. The bench provokes this and expects a fault with the flag unchanged. Both cases are judged against a behavioural model on every clock, and a long random stream of classes, levels and write values follows.

// File: rtl/sysop_pkg.sv
package sysop_pkg;

    localparam int LVL_W = 2;
    localparam int CLS_W = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN    = 4'd0,
        CLS_INT_OFF  = 4'd1,
        CLS_INT_ON   = 4'd2,
        CLS_PORT_IO  = 4'd3,
        CLS_TBL_LOAD = 4'd4,
        CLS_CTRL_MOV = 4'd5,
        CLS_HALT     = 4'd6,
        CLS_MSR      = 4'd7,
        CLS_TLB_INV  = 4'd8,
        CLS_IOPL_WR  = 4'd9
    } op_class_e;

    typedef enum logic [1:0] {
        RULE_NONE  = 2'd0,
        RULE_IOPL  = 2'd1,
        RULE_RING0 = 2'd2
    } rule_e;

    typedef struct packed {
        rule_e rule;
        logic  flag_wr;
        logic  flag_val;
        logic  iopl_wr;
    } op_attr_t;

    typedef struct packed {
        logic permit;
        logic fault;
    } verdict_t;

    function automatic op_attr_t classify(input logic [CLS_W-1:0] cls);
        op_attr_t a;
        a = '{rule: RULE_NONE, flag_wr: 1'b0, flag_val: 1'b0, iopl_wr: 1'b0};
        case (cls)
            CLS_INT_OFF: begin
                a.rule    = RULE_IOPL;
                a.flag_wr = 1'b1;
            end
            CLS_INT_ON: begin
                a.rule     = RULE_IOPL;
                a.flag_wr  = 1'b1;
                a.flag_val = 1'b1;
            end
            CLS_PORT_IO: a.rule = RULE_IOPL;
            CLS_TBL_LOAD, CLS_CTRL_MOV, CLS_HALT,
            CLS_MSR, CLS_TLB_INV: a.rule = RULE_RING0;
            CLS_IOPL_WR: begin
                a.rule    = RULE_RING0;
                a.iopl_wr = 1'b1;
            end
            default: a.rule = RULE_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sysop_classify.sv
module sysop_classify
    import sysop_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output op_attr_t         attr
);
    always_comb attr = classify(cls);
endmodule

// File: rtl/sysop_verdict.sv
module sysop_verdict
    import sysop_pkg::*;
(
    input  logic     valid,
    input  lvl_t     cpl,
    input  lvl_t     iopl,
    input  rule_e    rule,
    output verdict_t verdict
);
    logic ring0;
    logic io_ok;
    logic allowed;

    always_comb begin
        ring0 = (cpl == '0);
        io_ok = ring0 || (iopl >= cpl);
        case (rule)
            RULE_IOPL:  allowed = io_ok;
            RULE_RING0: allowed = ring0;
            default:    allowed = 1'b1;
        endcase
        verdict.permit = valid & allowed;
        verdict.fault  = valid & ~allowed;
    end
endmodule

// File: rtl/sysop_state.sv
module sysop_state
    import sysop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    input  logic     flag_wr,
    input  logic     flag_val,
    input  logic     iopl_wr,
    input  lvl_t     iopl_wdata,
    output logic     int_flag,
    output lvl_t     iopl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            int_flag <= 1'b0;
            iopl     <= '0;
        end else if (verdict.permit) begin
            if (flag_wr) int_flag <= flag_val;
            if (iopl_wr) iopl     <= iopl_wdata;
        end
    end

    // R7
    flag_update_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict.permit && flag_wr) |=> (int_flag == $past(flag_val)));

    // R6
    deny_hold_chk: assert property (@(posedge clk) disable iff (rst)
        verdict.fault |=> ($stable(int_flag) && $stable(iopl)));
endmodule

// File: rtl/sysop_gate.sv
module sysop_gate
    import sysop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [LVL_W-1:0] cs_sel_lo,
    input  logic [CLS_W-1:0] op_class,
    input  logic [LVL_W-1:0] iopl_wdata,
    output logic             op_permit,
    output logic             op_gpfault,
    output logic             int_flag
);
    op_attr_t attr;
    verdict_t verdict;
    lvl_t     iopl;

    sysop_classify u_classify (
        .cls  (op_class),
        .attr (attr)
    );

    sysop_verdict u_verdict (
        .valid   (op_valid),
        .cpl     (cs_sel_lo),
        .iopl    (iopl),
        .rule    (attr.rule),
        .verdict (verdict)
    );

    sysop_state u_state (
        .clk        (clk),
        .rst        (rst),
        .verdict    (verdict),
        .flag_wr    (attr.flag_wr),
        .flag_val   (attr.flag_val),
        .iopl_wr    (attr.iopl_wr),
        .iopl_wdata (iopl_wdata),
        .int_flag   (int_flag),
        .iopl       (iopl)
    );

    assign op_permit  = verdict.permit;
    assign op_gpfault = verdict.fault;

    // R10
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $onehot({op_permit, op_gpfault}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !(op_permit || op_gpfault));

    // R5
    strict_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cs_sel_lo != '0 && op_class >= CLS_TBL_LOAD
         && op_class <= CLS_IOPL_WR) |-> op_gpfault);

    // R9
    plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_class == CLS_PLAIN || op_class > CLS_IOPL_WR)) |-> op_permit);

    // R8
    iopl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_permit && op_class == CLS_IOPL_WR) |=> (iopl == $past(iopl_wdata)));
endmodule

// File: tb/test_sysop_gate.sv
`timescale 1ns/1ps
module test_sysop_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] cs_sel_lo = 2'd0;
    logic [3:0] op_class = 4'd0;
    logic [1:0] iopl_wdata = 2'd0;
    logic       op_permit, op_gpfault, int_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int m_flag = 0;
    int m_iopl = 0;

    always #2.5 clk = ~clk;

    sysop_gate i_sysop_gate (
        .clk (clk), .rst (rst), .op_valid (op_valid), .cs_sel_lo (cs_sel_lo),
        .op_class (op_class), .iopl_wdata (iopl_wdata),
        .op_permit (op_permit), .op_gpfault (op_gpfault), .int_flag (int_flag)
    );

    function automatic string tag_of(input int v, input int k);
        if (!v) return "R10";
        if (k == 1 || k == 2) return "R3";
        if (k == 3) return "R4";
        if (k >= 4 && k <= 8) return "R5";
        if (k == 9) return "R8";
        return "R9";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input int v, input int c, input int k, input int w, input string tag);
        int ok;
        string t;
        @(negedge clk);
        op_valid = v[0]; cs_sel_lo = c[1:0]; op_class = k[3:0]; iopl_wdata = w[1:0];
        #1;
        t = (tag == "") ? tag_of(v, k) : tag;
        if (k >= 1 && k <= 3)      ok = (c == 0 || m_iopl >= c);
        else if (k >= 4 && k <= 9) ok = (c == 0);
        else                       ok = 1;
        if (!v) begin
            check(t, "permit", op_permit, 0);
            check(t, "fault", op_gpfault, 0);
        end else begin
            check(t, "permit", op_permit, ok);
            check(t, "fault", op_gpfault, !ok);
        end
        check("R7", "int_flag", int_flag, m_flag);
        if (v && ok) begin
            if (k == 1) m_flag = 0;
            if (k == 2) m_flag = 1;
            if (k == 9) m_iopl = w;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R1", "int_flag", int_flag, 0);
        m_flag = 0; m_iopl = 0;
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        step(1, 3, 3, 0, "R1");          // level 0 after reset: port I/O at 3 faults
        step(1, 0, 2, 0, "R7");          // enable at level 0
        step(0, 0, 0, 0, "R7");          // flag now 1
        step(1, 2, 1, 0, "R6");          // denied disable, flag held
        step(0, 0, 0, 0, "R6");
        step(1, 1, 9, 3, "R8");          // write at level 1 faults
        step(1, 3, 3, 0, "R8");          // level still 0
        step(1, 0, 9, 2, "R8");          // write level 2
        step(1, 2, 1, 0, "R3");          // uses new level at once
        step(1, 3, 2, 0, "R3");          // 2 < 3: fault
        step(1, 2, 3, 0, "R4");
        step(1, 3, 3, 0, "R4");
        for (int k = 4; k <= 9; k++) step(1, 0, k, 2, "R2");
        for (int k = 4; k <= 8; k++) step(1, 1, k, 0, "R5");
        step(1, 3, 0, 0, "R9");
        step(1, 3, 12, 0, "R9");
        step(1, 3, 15, 0, "R9");
        step(0, 3, 6, 0, "R10");
        for (int i = 0; i < 4000; i++)
            step(($urandom % 8) != 0, $urandom % 4, $urandom % 16, $urandom % 4, "");
        do_reset();
        step(1, 1, 3, 0, "R1");
        step(1, 1, 1, 0, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule